// File: doc/BRIEF.md
# Asynchronous Parallel Memory Read Controller

This block sits on the host side of an asynchronous byte-wide non-volatile memory that has a 16-bit address bus, an active-low chip-select strobe and an active-low output-gate strobe. A client hands it one address at a time over a valid/ready handshake. The block drives the address and the chip-select strobe. It waits a lead interval and then opens the output gate. After a second interval it samples the data lines. It returns the byte with a one-cycle response pulse and closes the strobes again.

Every analog delay is expressed as a whole number of clock cycles. `ACCESS_CYC` is the address- and select-to-data time, `OE_CYC` is the gate-to-data time and `HIZ_CYC` is the float time after the strobes close. Each value is rounded up by the integrator. Because the gate-to-data time is shorter, the gate opens `ACCESS_CYC - OE_CYC` cycles after select, and both delays end on the same edge. After the strobes close, the controller stays busy for `HIZ_CYC` cycles, so that no other device is granted the shared data lines while this memory may still be driving them.

The parameter `KEEP_CE` picks a back-to-back variant. In this variant the select strobe is not released at the end of a read. It stays low through the float wait. It is raised only when no new request arrives in the first ready cycle, which saves select-strobe transitions in streams of consecutive reads.

Top module: `pmem_rd_ctrl`

## Requirements
- R1: A synchronous reset, applied even during a read, leaves both strobes high, `rsp_valid` low and `req_ready` high on the cycle after the reset edge.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. From the next cycle, `mem_ce_n` is low, `mem_addr` carries the request address and `req_ready` is low.
- R3: `mem_oe_n` goes low exactly `ACCESS_CYC - OE_CYC` cycles after acceptance. It stays low for exactly `OE_CYC` cycles.
- R4: The data lines are sampled on the edge `ACCESS_CYC` cycles after acceptance, while `mem_oe_n` is still low. `rsp_data` holds the sampled byte, and `rsp_valid` is high for exactly one cycle, the cycle after that edge.
- R5: With `KEEP_CE = 0`, both strobes rise on the sampling edge. With `KEEP_CE = 1`, only `mem_oe_n` rises there.
- R6: `req_ready` stays low for exactly `ACCESS_CYC + HIZ_CYC` cycles after acceptance and is then high. The strobes therefore stay high for at least `HIZ_CYC` cycles before the next read opens the gate.
- R7: `mem_addr` does not change from acceptance until `req_ready` is high again.
- R8: With `KEEP_CE = 1`, `mem_ce_n` stays low across reads when the next request is accepted in the first ready cycle. It rises on the next edge when that cycle passes without a request.
- R9: `req_valid` and `req_addr` applied while `req_ready` is low do not affect `mem_addr` or the strobe sequence. The pending request is accepted in the first ready cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds a fresh byte |
| rsp_data | output | DATA_W | Byte read from memory |
| mem_addr | output | ADDR_W | Address bus to the memory |
| mem_ce_n | output | 1 | Chip-select strobe, active low |
| mem_oe_n | output | 1 | Output-gate strobe, active low |
| mem_data | input | DATA_W | Data lines from the memory |

## Verification
The memory model on the bench returns its stored byte only once select, gate and address have each been held for their full cycle counts. Otherwise it returns a filler value, so a sampling edge that comes a cycle early, or a gate that opens late, shows up as wrong data as well as wrong strobe timing. Reads at all-zero, all-one and mixed addresses show that the address path is complete and in the right bit order.

Three request patterns are tried. Isolated reads show the full release. Requests held while the controller is busy show that they are ignored until the first ready cycle. Back-to-back streams run on a default instance and a hold-select instance side by side, which tells the two release policies apart. A reset in the middle of a read shows that the strobes are forced idle from any state.

// File: rtl/pmem_rd_pkg.sv
package pmem_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LEAD   = 2'd1,
    ST_STROBE = 2'd2,
    ST_GAP    = 2'd3
  } rd_state_e;

  // cycles between select-low and gate-low
  function automatic int lead_cycles(input int access_cyc, input int oe_cyc);
    return access_cyc - oe_cyc;
  endfunction

  // cycles from acceptance until the controller is ready again
  function automatic int busy_cycles(input int access_cyc, input int hiz_cyc);
    return access_cyc + hiz_cyc;
  endfunction

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int timer_width(input int access_cyc, input int oe_cyc,
                                     input int hiz_cyc);
    int w;
    w = $clog2(max_of3(access_cyc, oe_cyc, hiz_cyc) + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/pmem_rd_timer.sv
module pmem_rd_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/pmem_rd_seq.sv
module pmem_rd_seq
  import pmem_rd_pkg::*;
#(
  parameter int ACCESS_CYC = 14,
  parameter int OE_CYC     = 8,
  parameter int HIZ_CYC    = 8,
  parameter bit KEEP_CE    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  output logic req_ready,
  output logic ce_n,
  output logic oe_n,
  output logic acc_evt,
  output logic cap_evt
);

  localparam int LEAD_CYC = lead_cycles(ACCESS_CYC, OE_CYC);
  localparam int CNT_W    = timer_width(ACCESS_CYC, OE_CYC, HIZ_CYC);
  localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'((LEAD_CYC > 0) ? LEAD_CYC - 1 : 0);
  localparam logic [CNT_W-1:0] OE_LD   = CNT_W'(OE_CYC - 1);
  localparam logic [CNT_W-1:0] HIZ_LD  = CNT_W'(HIZ_CYC - 1);

  rd_state_e        state;
  logic             expired;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  assign req_ready = (state == ST_IDLE);
  assign acc_evt   = (state == ST_IDLE) && req_valid;
  assign cap_evt   = (state == ST_STROBE) && expired;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: begin
        tmr_load = acc_evt;
        tmr_val  = (LEAD_CYC > 0) ? LEAD_LD : OE_LD;
      end
      ST_LEAD: begin
        tmr_load = expired;
        tmr_val  = OE_LD;
      end
      ST_STROBE: begin
        tmr_load = expired;
        tmr_val  = HIZ_LD;
      end
      default: begin
        tmr_load = 1'b0;
        tmr_val  = '0;
      end
    endcase
  end

  pmem_rd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (acc_evt) begin
            ce_n <= 1'b0;
            if (LEAD_CYC > 0) begin
              state <= ST_LEAD;
            end else begin
              oe_n  <= 1'b0;
              state <= ST_STROBE;
            end
          end else begin
            ce_n <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (expired) begin
            oe_n  <= 1'b0;
            state <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (expired) begin
            oe_n  <= 1'b1;
            if (!KEEP_CE) ce_n <= 1'b1;
            state <= ST_GAP;
          end
        end
        default: begin
          if (expired) state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/pmem_rd_capture.sv
module pmem_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_evt,
  input  logic [DATA_W-1:0] mem_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cap_evt;
      if (cap_evt) rsp_data <= mem_data;
    end
  end

endmodule

// File: rtl/pmem_rd_ctrl.sv
module pmem_rd_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int ACCESS_CYC = 14,
  parameter int OE_CYC     = 8,
  parameter int HIZ_CYC    = 8,
  parameter bit KEEP_CE    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_data
);

  logic acc_evt;
  logic cap_evt;

  pmem_rd_seq #(
    .ACCESS_CYC (ACCESS_CYC),
    .OE_CYC     (OE_CYC),
    .HIZ_CYC    (HIZ_CYC),
    .KEEP_CE    (KEEP_CE)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .acc_evt   (acc_evt),
    .cap_evt   (cap_evt)
  );

  pmem_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .cap_evt   (cap_evt),
    .mem_data  (mem_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
    end else if (acc_evt) begin
      mem_addr <= req_addr;
    end
  end

endmodule

// File: rtl/pmem_rd_ctrl_chk.sv
module pmem_rd_ctrl_chk #(
  parameter int ADDR_W     = 16,
  parameter int ACCESS_CYC = 14,
  parameter int OE_CYC     = 8,
  parameter int HIZ_CYC    = 8,
  parameter bit KEEP_CE    = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              acc_evt,
  input logic              cap_evt
);

  logic [15:0] since_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_acc <= '0;
    end else if (acc_evt) begin
      since_acc <= '0;
    end else if (since_acc != 16'hFFFF) begin
      since_acc <= since_acc + 16'd1;
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_ce_n && mem_oe_n && !rsp_valid && req_ready));

  // R2
  accept_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    acc_evt |=> (!mem_ce_n && !req_ready));

  // R3
  oe_lead_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> (32'(since_acc) == ACCESS_CYC - OE_CYC));

  // R4
  rsp_time_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rsp_valid) && !$past(rst)) |-> (32'(since_acc) == ACCESS_CYC));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (mem_oe_n && (KEEP_CE || mem_ce_n)));

  // R6
  ready_time_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_ready) && !$past(rst)) |-> (32'(since_acc) == ACCESS_CYC + HIZ_CYC));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

endmodule

bind pmem_rd_ctrl pmem_rd_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .ACCESS_CYC (ACCESS_CYC),
  .OE_CYC     (OE_CYC),
  .HIZ_CYC    (HIZ_CYC),
  .KEEP_CE    (KEEP_CE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .acc_evt   (acc_evt),
  .cap_evt   (cap_evt)
);

// File: tb/pmem_rd_ctrl_bench.sv
`timescale 1ns/1ps

package pmem_bench_pkg;
  function automatic logic [7:0] cell_value(input logic [15:0] a);
    logic [7:0] s;
    s = a[15:8] + {a[6:0], a[7]};
    return s ^ 8'h3C;
  endfunction
endpackage

module pmem_rd_model #(
  parameter int ACC = 7,
  parameter int OEC = 3
) (
  input  logic        clk,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic [15:0] addr,
  output logic [7:0]  data
);
  int          ce_cnt;
  int          oe_cnt;
  int          ad_cnt;
  logic [15:0] last_addr;

  initial begin
    ce_cnt = 0; oe_cnt = 0; ad_cnt = 0; last_addr = '0;
  end

  always @(posedge clk) begin
    ce_cnt    <= ce_n ? 0 : ((ce_cnt < 1000) ? ce_cnt + 1 : ce_cnt);
    oe_cnt    <= oe_n ? 0 : ((oe_cnt < 1000) ? oe_cnt + 1 : oe_cnt);
    ad_cnt    <= (addr != last_addr) ? 0 : ((ad_cnt < 1000) ? ad_cnt + 1 : ad_cnt);
    last_addr <= addr;
  end

  assign data = (!ce_n && !oe_n && ce_cnt >= ACC - 1 && oe_cnt >= OEC - 1 &&
                 ad_cnt >= ACC - 2) ? pmem_bench_pkg::cell_value(addr) : 8'hEE;
endmodule

module pmem_rd_ctrl_bench;
  import pmem_bench_pkg::*;

  localparam int A    = 7;
  localparam int O    = 3;
  localparam int H    = 2;
  localparam int LEAD = A - O;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;

  logic        rdy, rsp_v, ce_n, oe_n;
  logic [7:0]  rsp_d, mdat;
  logic [15:0] maddr;
  logic        rdy_k, rsp_v_k, ce_n_k, oe_n_k;
  logic [7:0]  rsp_d_k, mdat_k;
  logic [15:0] maddr_k;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pmem_rd_ctrl #(.ACCESS_CYC(A), .OE_CYC(O), .HIZ_CYC(H), .KEEP_CE(1'b0)) u_pmem_rd_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy), .req_addr(req_addr),
    .rsp_valid(rsp_v), .rsp_data(rsp_d), .mem_addr(maddr), .mem_ce_n(ce_n),
    .mem_oe_n(oe_n), .mem_data(mdat));

  pmem_rd_ctrl #(.ACCESS_CYC(A), .OE_CYC(O), .HIZ_CYC(H), .KEEP_CE(1'b1)) u_pmem_rd_ctrl_keep (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_k), .req_addr(req_addr),
    .rsp_valid(rsp_v_k), .rsp_data(rsp_d_k), .mem_addr(maddr_k), .mem_ce_n(ce_n_k),
    .mem_oe_n(oe_n_k), .mem_data(mdat_k));

  pmem_rd_model #(.ACC(A), .OEC(O)) u_mem (
    .clk(clk), .ce_n(ce_n), .oe_n(oe_n), .addr(maddr), .data(mdat));
  pmem_rd_model #(.ACC(A), .OEC(O)) u_mem_k (
    .clk(clk), .ce_n(ce_n_k), .oe_n(oe_n_k), .addr(maddr_k), .data(mdat_k));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    finished = 1'b1;
    $finish;
  endtask

  // called at a negedge; returns right after the accepting posedge
  task automatic start(input logic [15:0] a);
    req_valid = 1'b1;
    req_addr  = a;
    while (!rdy) @(negedge clk);
    @(posedge clk);
  endtask

  // follows one read from the accepting edge to its first ready cycle
  task automatic observe(input logic [15:0] a, input bit nv, input logic [15:0] na);
    for (int n = 1; n <= A + H + 1; n++) begin
      @(negedge clk);
      if (n == 1) begin
        req_valid = nv;
        req_addr  = na;
        chk(ce_n == 1'b0 && rdy == 1'b0, "R2 select low and busy after accept",
            {ce_n, rdy}, 2'b00);
      end
      if (n <= A + H) begin
        chk(maddr == a, "R7 address held while busy", maddr, a);
        chk(maddr_k == a, "R7 address held while busy (hold-select)", maddr_k, a);
      end
      chk(oe_n == !(n > LEAD && n <= A), "R3 gate strobe window", oe_n,
          !(n > LEAD && n <= A));
      chk(ce_n == (n > A), "R5 select released at sample", ce_n, (n > A));
      chk(oe_n_k == oe_n, "R5 gate strobe same in hold-select mode", oe_n_k, oe_n);
      chk(ce_n_k == 1'b0, "R8 select held low in hold-select mode", ce_n_k, 1'b0);
      chk(rsp_v == (n == A + 1), "R4 response pulse timing", rsp_v, (n == A + 1));
      if (n == A + 1) begin
        chk(rsp_d == cell_value(a), "R4 response data", rsp_d, cell_value(a));
        chk(rsp_d_k == cell_value(a), "R4 response data (hold-select)", rsp_d_k,
            cell_value(a));
      end
      chk(rdy == (n == A + H + 1), "R6 ready after access plus float wait", rdy,
          (n == A + H + 1));
    end
  endtask

  task automatic t_reset_state();
    chk(ce_n && oe_n && !rsp_v && rdy, "R1 state after reset",
        {ce_n, oe_n, rsp_v, rdy}, 4'b1101);
    chk(ce_n_k && oe_n_k && !rsp_v_k && rdy_k, "R1 state after reset (hold-select)",
        {ce_n_k, oe_n_k, rsp_v_k, rdy_k}, 4'b1101);
  endtask

  task automatic t_single_reads();
    logic [15:0] addrs [4];
    addrs = '{16'h0000, 16'hFFFF, 16'h1234, 16'hA5C3};
    foreach (addrs[i]) begin
      start(addrs[i]);
      observe(addrs[i], 1'b0, 16'h0000);
      @(negedge clk);
      chk(ce_n && oe_n, "R5 strobes idle between isolated reads", {ce_n, oe_n}, 2'b11);
      chk(ce_n_k == 1'b1, "R8 hold-select releases after an idle ready cycle",
          ce_n_k, 1'b1);
    end
  endtask

  task automatic t_busy_ignore();
    start(16'h00FF);
    observe(16'h00FF, 1'b1, 16'h8001);
    chk(maddr == 16'h00FF, "R9 busy-time request left address alone", maddr, 16'h00FF);
    @(posedge clk);
    observe(16'h8001, 1'b0, 16'h0000);
    chk(rsp_d == cell_value(16'h8001), "R9 pending request served next", rsp_d,
        cell_value(16'h8001));
    @(negedge clk);
  endtask

  task automatic t_back_to_back();
    start(16'h1234);
    observe(16'h1234, 1'b1, 16'hFFFF);
    @(posedge clk);
    observe(16'hFFFF, 1'b1, 16'h0000);
    @(posedge clk);
    observe(16'h0000, 1'b0, 16'h0000);
    @(negedge clk);
    chk(ce_n_k == 1'b1, "R8 hold-select raises select when idle", ce_n_k, 1'b1);
    chk(ce_n == 1'b1, "R5 default select high when idle", ce_n, 1'b1);
  endtask

  task automatic t_reset_mid();
    start(16'hA5C3);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(ce_n && oe_n && !rsp_v && rdy, "R1 reset during read",
        {ce_n, oe_n, rsp_v, rdy}, 4'b1101);
    chk(ce_n_k && oe_n_k && !rsp_v_k && rdy_k, "R1 reset during read (hold-select)",
        {ce_n_k, oe_n_k, rsp_v_k, rdy_k}, 4'b1101);
    @(negedge clk);
    chk(ce_n && oe_n && rdy, "R1 stays idle after reset", {ce_n, oe_n, rdy}, 3'b111);
    start(16'h1234);
    observe(16'h1234, 1'b0, 16'h0000);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_single_reads();
    t_busy_ignore();
    t_back_to_back();
    t_reset_mid();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

endmodule